// File: doc/BRIEF.md
# Multi-Mode Conversion Result Readout

This block sits between a two-converter sampling core and a host. The core hands over each finished 12-bit result with a strobe and the number of the channel it belongs to. The block keeps these results in six slots. The host fetches them one word per read strobe. Each word carries the result, the channel it came from and a flag that shows whether the slot held fresh data.

A 3-bit mode input selects how the six slots are used, and it can change at run time. Values 0 to 5 read the slot of that channel directly. Value 6 steps through the six channel slots in turn, one per read. Value 7 treats the six slots as a first-in-first-out queue that returns results in the order they arrived. In the queue mode any channels may fill it; for example a single channel pair can leave three results each before the host reads anything. A sticky flag reports results lost to a full queue.

Top module: `result_readout`

## Requirements
- R1: Every read word has the valid flag in bit 15, the 3-bit channel number in bits 14:12 and the 12-bit result in bits 11:0. A word with the flag set always carries a channel number from 0 to 5.
- R2: While reset is low, and after it is released until the first read, the read word is all zeros and the overflow flag is low. All slots are empty and the cycling position is channel 0.
- R3: With mode 0 to 5, a read returns the slot of that channel. In the modes other than 7, a write stores its result in the slot of its channel. A write naming channel 6 or 7 is ignored in every mode.
- R4: A read empties the slot it returns. Reading an empty slot in modes 0 to 6 returns flag 0, the addressed channel number and data 0.
- R5: In mode 6, each read returns the slot at the cycling position and then advances the position by one, going from 5 back to 0. Reads in other modes leave the position unchanged.
- R6: In mode 7, reads return the stored results with their channel numbers in the order the writes were accepted. Up to six results from any channels may be held.
- R7: A read of the empty queue in mode 7 returns an all-zero word.
- R8: In mode 7, a write to a full queue in a cycle without a read is dropped and sets the overflow flag. A write to a full queue in the same cycle as a read is accepted. The overflow flag stays set until reset.
- R9: When a write and a read hit the same slot in the same cycle, the read returns the earlier contents and the new result stays stored and valid.
- R10: In the first cycle in which the mode changes from 7 to another value, or from another value to 7, all slots and the queue are emptied. The write and the read of that cycle are ignored, and the read word keeps its value.
- R11: The read word changes only in the cycle after an accepted read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously inside |
| wr_en | input | 1 | Result strobe from the converter core |
| wr_ch | input | 3 | Channel number of the strobed result |
| wr_data | input | 12 | Converted result |
| rd_en | input | 1 | Host read strobe |
| mode | input | 3 | 0-5 addressed channel, 6 cycling, 7 queue |
| rd_word | output | 16 | Last word read: valid, channel, data |
| ovf | output | 1 | Sticky queue overflow flag |

## Verification
A result write and a host read can fall in the same cycle. In the direct modes they can hit the same slot. In queue mode a push can coincide with a pop, either on a full queue or on an empty one. The bench forces these collisions with directed steps and, in large numbers, with random strobes that stay on one mode for long runs. Each outcome is judged against a bench model that applies the read before the write. The same applies to the mode change that empties the storage while strobes are active.

// File: rtl/result_readout_pkg.sv
package result_readout_pkg;
  localparam int unsigned CH_W       = 3;
  localparam logic [2:0]  MODE_CYCLE = 3'd6;
  localparam logic [2:0]  MODE_QUEUE = 3'd7;
endpackage

// File: rtl/rr_cycle_ptr.sv
module rr_cycle_ptr #(
  parameter int unsigned N_SLOT = 6,
  parameter int unsigned PW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [PW-1:0] ptr
);
  logic [PW-1:0] ptr_nx;

  always_comb begin
    ptr_nx = ptr;
    if (adv) begin
      if (ptr == PW'(N_SLOT - 1)) ptr_nx = '0;
      else                        ptr_nx = ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nx;
  end
endmodule

// File: rtl/rr_fifo_ctl.sv
module rr_fifo_ctl #(
  parameter int unsigned N_SLOT = 6,
  parameter int unsigned PW     = 3,
  parameter int unsigned CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push_req,
  input  logic             pop_req,
  output logic [PW-1:0]    head,
  output logic [PW-1:0]    tail,
  output logic [CNT_W-1:0] count,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             ovf_set
);
  logic [PW-1:0]    head_nx, tail_nx;
  logic [CNT_W-1:0] count_nx;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(N_SLOT - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    pop_ok  = pop_req && (count != '0);
    push_ok = push_req && ((count != CNT_W'(N_SLOT)) || pop_ok);
    ovf_set = push_req && !push_ok;
  end

  always_comb begin
    head_nx  = head;
    tail_nx  = tail;
    count_nx = count;
    if (clr) begin
      head_nx  = '0;
      tail_nx  = '0;
      count_nx = '0;
    end else begin
      if (pop_ok)  head_nx = wrap_inc(head);
      if (push_ok) tail_nx = wrap_inc(tail);
      case ({push_ok, pop_ok})
        2'b10:   count_nx = count + 1'b1;
        2'b01:   count_nx = count - 1'b1;
        default: count_nx = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head  <= head_nx;
      tail  <= tail_nx;
      count <= count_nx;
    end
  end
endmodule

// File: rtl/rr_slot.sv
module rr_slot #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clr,
  output logic              vld,
  output logic [CH_W-1:0]   ch,
  output logic [DATA_W-1:0] data
);
  logic              vld_nx;
  logic [CH_W-1:0]   ch_nx;
  logic [DATA_W-1:0] data_nx;

  always_comb begin
    vld_nx  = vld;
    ch_nx   = ch;
    data_nx = data;
    if (clr) begin
      vld_nx = 1'b0;
    end else if (wr) begin
      vld_nx  = 1'b1;
      ch_nx   = wr_ch;
      data_nx = wr_data;
    end else if (rd_clr) begin
      vld_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      ch   <= '0;
      data <= '0;
    end else begin
      vld  <= vld_nx;
      ch   <= ch_nx;
      data <= data_nx;
    end
  end
endmodule

// File: rtl/result_readout.sv
module result_readout
  import result_readout_pkg::*;
#(
  parameter int unsigned N_SLOT = 6,
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_ch,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [2:0]        mode,
  output logic [DATA_W+3:0] rd_word,
  output logic              ovf
);
  localparam int unsigned PW     = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;
  localparam int unsigned CNT_W  = $clog2(N_SLOT + 1);
  localparam int unsigned WORD_W = DATA_W + CH_W + 1;

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  // mode category tracking; a change empties the storage
  logic mode_fifo_q;
  logic fifo_now;
  logic flush;

  assign fifo_now = (mode == MODE_QUEUE);
  assign flush    = (fifo_now != mode_fifo_q);

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) mode_fifo_q <= 1'b0;
    else          mode_fifo_q <= fifo_now;
  end

  logic wr_ok, rd_ok;
  assign wr_ok = wr_en && (int'(wr_ch) < N_SLOT) && !flush;
  assign rd_ok = rd_en && !flush;

  // cycling position
  logic [PW-1:0] cyc_ptr;
  logic          cyc_adv;
  assign cyc_adv = rd_ok && !fifo_now && (mode == MODE_CYCLE);

  rr_cycle_ptr #(.N_SLOT(N_SLOT), .PW(PW)) u_cyc (
    .clk  (clk),
    .rst_n(rst_i_n),
    .adv  (cyc_adv),
    .ptr  (cyc_ptr)
  );

  // queue pointers
  logic [PW-1:0]    q_head, q_tail;
  logic [CNT_W-1:0] fifo_cnt;
  logic             push_ok, pop_ok, ovf_set;

  rr_fifo_ctl #(.N_SLOT(N_SLOT), .PW(PW), .CNT_W(CNT_W)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .clr     (flush),
    .push_req(wr_ok && fifo_now),
    .pop_req (rd_ok && fifo_now),
    .head    (q_head),
    .tail    (q_tail),
    .count   (fifo_cnt),
    .push_ok (push_ok),
    .pop_ok  (pop_ok),
    .ovf_set (ovf_set)
  );

  // read slot selection
  logic [PW-1:0] rd_idx;
  always_comb begin
    if (fifo_now)                 rd_idx = q_head;
    else if (mode == MODE_CYCLE)  rd_idx = cyc_ptr;
    else                          rd_idx = PW'(mode);
  end

  // slot storage
  logic [N_SLOT-1:0] slot_vld;
  logic [CH_W-1:0]   slot_ch   [N_SLOT];
  logic [DATA_W-1:0] slot_data [N_SLOT];

  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    logic wr_i, rdc_i;
    assign wr_i  = fifo_now ? (push_ok && (q_tail == PW'(i)))
                            : (wr_ok && (wr_ch == CH_W'(i)));
    assign rdc_i = rd_ok && (rd_idx == PW'(i));

    rr_slot #(.DATA_W(DATA_W), .CH_W(CH_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_i_n),
      .clr    (flush),
      .wr     (wr_i),
      .wr_ch  (wr_ch),
      .wr_data(wr_data),
      .rd_clr (rdc_i),
      .vld    (slot_vld[i]),
      .ch     (slot_ch[i]),
      .data   (slot_data[i])
    );
  end

  // output word
  logic              sel_vld;
  logic [CH_W-1:0]   sel_ch;
  logic [DATA_W-1:0] sel_data;
  logic [WORD_W-1:0] word_nx;

  always_comb begin
    sel_vld  = 1'b0;
    sel_ch   = '0;
    sel_data = '0;
    for (int i = 0; i < N_SLOT; i++) begin
      if (rd_idx == PW'(i)) begin
        sel_vld  = slot_vld[i];
        sel_ch   = slot_ch[i];
        sel_data = slot_data[i];
      end
    end
    if (sel_vld)       word_nx = {1'b1, sel_ch, sel_data};
    else if (fifo_now) word_nx = '0;
    else               word_nx = {1'b0, CH_W'(rd_idx), {DATA_W{1'b0}}};
  end

  logic ovf_nx;
  assign ovf_nx = ovf | ovf_set;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rd_word <= '0;
      ovf     <= 1'b0;
    end else begin
      if (rd_ok) rd_word <= word_nx;
      ovf <= ovf_nx;
    end
  end
endmodule

// File: rtl/result_readout_chk.sv
module result_readout_chk
  import result_readout_pkg::*;
#(
  parameter int unsigned N_SLOT = 6,
  parameter int unsigned DATA_W = 12,
  parameter int unsigned PW     = 3,
  parameter int unsigned CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [2:0]        mode,
  input logic [DATA_W+3:0] rd_word,
  input logic              ovf,
  input logic [PW-1:0]     cyc_ptr,
  input logic [CNT_W-1:0]  fifo_cnt,
  input logic [N_SLOT-1:0] slot_vld,
  input logic              mode_fifo_q
);
  // R1
  tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word[DATA_W+3] |-> (int'(rd_word[DATA_W+2:DATA_W]) < N_SLOT));

  // R4
  empty_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_word[DATA_W+3] |-> (rd_word[DATA_W-1:0] == '0));

  // R5
  cycle_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cyc_ptr) < N_SLOT);

  // R6
  slot_count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fifo_q |-> ($countones(slot_vld) == int'(fifo_cnt)));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R8
  ovf_queue_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> ($past(mode) == MODE_QUEUE));

  // R11
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_word));
endmodule

bind result_readout result_readout_chk #(
  .N_SLOT(N_SLOT), .DATA_W(DATA_W), .PW(PW), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_en      (rd_en),
  .mode       (mode),
  .rd_word    (rd_word),
  .ovf        (ovf),
  .cyc_ptr    (cyc_ptr),
  .fifo_cnt   (fifo_cnt),
  .slot_vld   (slot_vld),
  .mode_fifo_q(mode_fifo_q)
);

// File: tb/result_readout_tb.sv
`timescale 1ns/1ps
module result_readout_tb;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_ch;
  logic [11:0] wr_data;
  logic        rd_en;
  logic [2:0]  mode;
  logic [15:0] rd_word;
  logic        ovf;

  int n_chk;
  int n_fail;
  bit done;

  result_readout u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .rd_en(rd_en), .mode(mode), .rd_word(rd_word), .ovf(ovf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // bench model of the requirements
  logic        m_vld [6];
  logic [11:0] m_dat [6];
  logic [11:0] q_dat [6];
  logic [2:0]  q_ch  [6];
  int          q_n;
  int          m_cyc;
  bit          m_qmode;
  logic [15:0] e_word;
  logic        e_ovf;
  string       tag;

  task automatic model_reset();
    for (int i = 0; i < 6; i++) begin
      m_vld[i] = 1'b0; m_dat[i] = '0; q_dat[i] = '0; q_ch[i] = '0;
    end
    q_n = 0; m_cyc = 0; m_qmode = 1'b0; e_word = '0; e_ovf = 1'b0;
  endtask

  task automatic model(input logic we, input logic [2:0] wch, input logic [11:0] wd,
                       input logic re, input logic [2:0] md);
    bit qn_mode;
    int idx;
    qn_mode = (md == 3'd7);
    tag = re ? "R3" : "R11";
    if (qn_mode != m_qmode) begin
      m_qmode = qn_mode;
      for (int i = 0; i < 6; i++) m_vld[i] = 1'b0;
      q_n = 0;
      tag = "R10";
    end else if (qn_mode) begin
      if (re) begin
        if (q_n > 0) begin
          e_word = {1'b1, q_ch[0], q_dat[0]};
          for (int i = 0; i < 5; i++) begin q_dat[i] = q_dat[i+1]; q_ch[i] = q_ch[i+1]; end
          q_n--;
          tag = "R6";
        end else begin
          e_word = '0;
          tag = "R7";
        end
      end
      if (we && wch < 3'd6) begin
        if (q_n < 6) begin
          q_dat[q_n] = wd; q_ch[q_n] = wch; q_n++;
        end else begin
          e_ovf = 1'b1;
          tag = "R8";
        end
      end
    end else begin
      idx = (md == 3'd6) ? m_cyc : int'(md);
      if (re) begin
        e_word = m_vld[idx] ? {1'b1, 3'(idx), m_dat[idx]} : {1'b0, 3'(idx), 12'h000};
        tag = (md == 3'd6) ? "R5" : (m_vld[idx] ? "R3" : "R4");
        m_vld[idx] = 1'b0;
        if (md == 3'd6) m_cyc = (m_cyc + 1) % 6;
      end
      if (we && wch < 3'd6) begin
        if (re && int'(wch) == idx) tag = "R9";
        m_vld[wch] = 1'b1;
        m_dat[wch] = wd;
      end
    end
  endtask

  task automatic check16(input logic [15:0] act, input logic [15:0] exp, input string t);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FIFO check FAIL %s: rd_word actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic check1(input logic act, input logic exp, input string t);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("flag check FAIL %s: ovf actual %b expected %b", t, act, exp);
    end
  endtask

  // called at a falling edge; drives, advances the model, samples at the next falling edge
  task automatic step(input logic we, input logic [2:0] wch, input logic [11:0] wd,
                      input logic re, input logic [2:0] md);
    wr_en = we; wr_ch = wch; wr_data = wd; rd_en = re; mode = md;
    model(we, wch, wd, re, md);
    @(negedge clk);
    check16(rd_word, e_word, tag);
    check1(ovf, e_ovf, "R8");
  endtask

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("watchdog FAIL R11: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [2:0] cur_mode;
    n_chk = 0; n_fail = 0; done = 1'b0;
    void'($urandom(32'd4711));
    wr_en = 0; wr_ch = 0; wr_data = 0; rd_en = 0; mode = 3'd0;
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    check16(rd_word, 16'h0000, "R2");
    check1(ovf, 1'b0, "R2");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check16(rd_word, 16'h0000, "R2");

    // R3 R1: addressed writes then addressed reads
    for (int c = 0; c < 6; c++) step(1, 3'(c), 12'h100 + 12'(c), 0, 3'd0);
    step(1, 3'd7, 12'hFFF, 0, 3'd0);       // ignored channel
    step(1, 3'd6, 12'hEEE, 0, 3'd0);       // ignored channel
    for (int c = 5; c >= 0; c--) step(0, 0, 0, 1, 3'(c));
    // R4: read again, now empty
    step(0, 0, 0, 1, 3'd2);
    // R9: same-slot write and read
    step(1, 3'd4, 12'hABC, 0, 3'd0);
    step(1, 3'd4, 12'h123, 1, 3'd4);
    step(0, 0, 0, 1, 3'd4);
    // R5: cycling with wrap
    for (int c = 0; c < 6; c++) step(1, 3'(c), 12'h200 + 12'(c), 0, 3'd6);
    for (int k = 0; k < 8; k++) step(0, 0, 0, 1, 3'd6);
    // R10 R6 R8 R7: queue mode, one pair fills it
    step(1, 3'd0, 12'h555, 1, 3'd7);       // flush cycle, ignored
    for (int k = 0; k < 3; k++) begin
      step(1, 3'd0, 12'h300 + 12'(k), 0, 3'd7);
      step(1, 3'd1, 12'h310 + 12'(k), 0, 3'd7);
    end
    step(1, 3'd1, 12'h3FF, 0, 3'd7);       // dropped, overflow
    step(1, 3'd0, 12'h3EE, 1, 3'd7);       // full with read: accepted
    for (int k = 0; k < 7; k++) step(0, 0, 0, 1, 3'd7);
    step(1, 3'd5, 12'h3AA, 1, 3'd7);       // empty queue push and pop
    step(0, 0, 0, 1, 3'd7);
    step(1, 3'd2, 12'h444, 0, 3'd7);
    step(0, 0, 0, 1, 3'd2);                // flush back to addressed

    // random phase
    cur_mode = 3'd7;
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 99) < 3) cur_mode = 3'($urandom_range(0, 7));
      if (cur_mode < 3'd6 && $urandom_range(0, 3) == 0) cur_mode = 3'($urandom_range(0, 5));
      step($urandom_range(0, 9) < 6, 3'($urandom_range(0, 7)), 12'($urandom),
           $urandom_range(0, 9) < 5, cur_mode);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule